// File: doc/BRIEF.md
# Write-Enable Gated Control Register

This block is the control and status register of a serial memory and supply-supervisor device. Every write aimed at the memory array, at the potentiometer wiper or at the register itself must pass through it first. Two volatile latches gate those writes. The write-enable latch must be set before anything is written. The register-unlock latch must then be set before the stored configuration fields can change. A write that is refused produces an acknowledge-suppress pulse in the same cycle, so the bus side can withhold its acknowledge after the data byte.

The configuration fields model the nonvolatile part of the device: a 2-bit block-lock partition select and a 2-bit power-up delay select. They keep their value through reset. A write to them is first staged. It is committed when the following STOP arrives, which raises a one-cycle commit request and then a busy flag for a fixed number of cycles. While busy is high, every write is refused. Two supply-monitor flags are sampled into the status byte and cannot be written.

Top module: `wr_gate_ctrl_reg`

## Requirements
- R1: After reset, the write-enable latch, the unlock latch, any staged commit and both monitor flags are 0. The configuration nibble `status_q[7:4]` keeps its value from before the reset. Status byte layout: bit0 = monitor-2 flag, bit1 = write enable, bit2 = unlock, bit3 = monitor-3 flag, bits 5:4 = block-lock select, bits 7:6 = power-up delay select.
- R2: When not busy and unlock is 0, a register byte of 0x02 sets write enable and a byte of 0x00 clears it. Both are acknowledged in either write-enable state, and neither stages a commit.
- R3: With write enable at 0, every array write, every wiper write and every register byte other than 0x00 and 0x02 is refused. A refusal means `wr_nak` is high, `wr_ack` is low and no state changes. `wr_ack` and `wr_nak` are never high together.
- R4: The byte 0x06 sets unlock only while write enable is 1. Unlock is never 1 while write enable is 0.
- R5: With write enable 1 and unlock 0, any register byte other than 0x00, 0x02 and 0x06 is refused and changes nothing.
- R6: With unlock 1, any register byte is accepted. Data bits 7:4 are staged for the configuration nibble, data bit 1 becomes the new write enable, and unlock clears.
- R7: A STOP with a staged value pulses `commit_req` in that same cycle. The nibble then takes the staged value, and `busy` is high for exactly COMMIT_CYCLES cycles. A STOP with nothing staged raises neither signal.
- R8: While `busy` is high, every register, array and wiper write is refused, and neither latch changes.
- R9: With write enable 1, an array write without a lock hit is acknowledged. An array write with a lock hit is refused, clears unlock and leaves write enable unchanged.
- R10: With write enable 1, a wiper write is refused when the block-lock select is non-zero (default variant) and acknowledged when it is zero.
- R11: Register writes never change the monitor flags. Each flag shows its monitor input one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register data byte |
| arr_wr_req | input | 1 | Array write request strobe |
| wiper_wr_req | input | 1 | Wiper write request strobe |
| lock_hit | input | 1 | Array target lies in the locked partition |
| stop_seen | input | 1 | Bus STOP indication |
| mon2_trip | input | 1 | Monitor-2 output |
| mon3_trip | input | 1 | Monitor-3 output |
| wel_q | output | 1 | Write-enable latch |
| rwel_q | output | 1 | Register-unlock latch |
| wr_ack | output | 1 | Current request accepted |
| wr_nak | output | 1 | Current request refused; withhold acknowledge |
| commit_req | output | 1 | Start of a nonvolatile commit |
| busy | output | 1 | Commit in progress |
| status_q | output | DATA_W | Status byte |

## Verification
Every one of the 256 register bytes is written from each of the three latch states: locked, enabled and unlocked. Each write is followed by a STOP. This sweep tells apart the bytes that only move write enable, the byte that unlocks, the illegal bytes and the staged commits. It also shows whether the monitor flags can be written. Array and wiper requests are tried against all four block-lock selects, with and without a lock hit, which tells the lock refusal apart from the write-enable refusal. Requests issued while a commit is in progress check that refusal takes priority.

// File: rtl/wgcr_pkg.sv
package wgcr_pkg;
   localparam int STATUS_W   = 8;
   localparam int POS_FLAG2  = 0;
   localparam int POS_WEL    = 1;
   localparam int POS_RWEL   = 2;
   localparam int POS_FLAG3  = 3;
   localparam int POS_CFG_LO = 4;

   localparam logic [STATUS_W-1:0] CMD_WEL_OFF = 8'h00;
   localparam logic [STATUS_W-1:0] CMD_WEL_ON  = 8'h02;
   localparam logic [STATUS_W-1:0] CMD_UNLOCK  = 8'h06;

   typedef enum logic [1:0] {
      RK_WEL  = 2'd0,
      RK_UNLK = 2'd1,
      RK_CFG  = 2'd2
   } reg_kind_e;
endpackage

// File: rtl/wgcr_permit.sv
module wgcr_permit
   import wgcr_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int BL_W           = 2,
   parameter bit WIPER_LOCK_ANY = 1'b1
) (
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              arr_wr_req,
   input  logic              wiper_wr_req,
   input  logic              lock_hit,
   input  logic              wel,
   input  logic              rwel,
   input  logic              busy,
   input  logic [BL_W-1:0]   bl,
   output logic              reg_take,
   output reg_kind_e         reg_kind,
   output logic              wr_ack,
   output logic              wr_nak,
   output logic              lock_clr
);
   logic wiper_locked;
   logic reg_legal;
   logic arr_sel, wip_sel, arr_take, wip_take, any_req;

   generate
      if (WIPER_LOCK_ANY) begin : g_lock_any
         assign wiper_locked = |bl;
      end else begin : g_lock_full
         assign wiper_locked = &bl;
      end
   endgenerate

   always_comb begin
      reg_kind  = RK_WEL;
      reg_legal = 1'b0;
      if (rwel) begin
         reg_kind  = RK_CFG;
         reg_legal = 1'b1;
      end else if (reg_wdata == DATA_W'(CMD_WEL_OFF) || reg_wdata == DATA_W'(CMD_WEL_ON)) begin
         reg_kind  = RK_WEL;
         reg_legal = 1'b1;
      end else if (reg_wdata == DATA_W'(CMD_UNLOCK) && wel) begin
         reg_kind  = RK_UNLK;
         reg_legal = 1'b1;
      end
   end

   assign any_req  = reg_wr | arr_wr_req | wiper_wr_req;
   assign arr_sel  = arr_wr_req & ~reg_wr;
   assign wip_sel  = wiper_wr_req & ~reg_wr & ~arr_wr_req;

   assign reg_take = reg_wr & ~busy & reg_legal;
   assign arr_take = arr_sel & ~busy & wel & ~lock_hit;
   assign wip_take = wip_sel & ~busy & wel & ~wiper_locked;
   assign lock_clr = arr_sel & ~busy & wel & lock_hit;

   assign wr_ack   = reg_take | arr_take | wip_take;
   assign wr_nak   = any_req & ~wr_ack;
endmodule

// File: rtl/wgcr_latch_seq.sv
module wgcr_latch_seq
   import wgcr_pkg::*;
#(
   parameter int NV_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_take,
   input  reg_kind_e       reg_kind,
   input  logic            wel_bit,
   input  logic [NV_W-1:0] cfg_bits,
   input  logic            lock_clr,
   input  logic            commit,
   output logic            wel_q,
   output logic            rwel_q,
   output logic            pend_q,
   output logic [NV_W-1:0] stage_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_q   <= 1'b0;
         rwel_q  <= 1'b0;
         pend_q  <= 1'b0;
         stage_q <= '0;
      end else begin
         if (commit) pend_q <= 1'b0;
         if (reg_take) begin
            case (reg_kind)
               RK_WEL:  wel_q  <= wel_bit;
               RK_UNLK: rwel_q <= 1'b1;
               RK_CFG: begin
                  wel_q   <= wel_bit;
                  rwel_q  <= 1'b0;
                  stage_q <= cfg_bits;
                  pend_q  <= 1'b1;
               end
               default: ;
            endcase
         end else if (lock_clr) begin
            rwel_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/wgcr_nv_store.sv
module wgcr_nv_store #(
   parameter int              NV_W          = 4,
   parameter int              COMMIT_CYCLES = 32,
   parameter logic [NV_W-1:0] NV_INIT       = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stop_seen,
   input  logic            pend,
   input  logic [NV_W-1:0] stage,
   output logic            commit_req,
   output logic            busy,
   output logic [NV_W-1:0] nv_q
);
   localparam int CNT_W = $clog2(COMMIT_CYCLES + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [NV_W-1:0]  cells = NV_INIT;

   assign busy       = (cnt_q != '0);
   assign commit_req = stop_seen & pend & ~busy;
   assign nv_q       = cells;

   // Modelled nonvolatile cells: deliberately outside the reset domain.
   always_ff @(posedge clk) begin
      if (commit_req) cells <= stage;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (commit_req) cnt_q <= CNT_W'(COMMIT_CYCLES);
      else if (busy)       cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/wgcr_mon_flags.sv
module wgcr_mon_flags #(
   parameter int NUM_MON = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_MON-1:0] trip,
   output logic [NUM_MON-1:0] flag
);
   generate
      for (genvar i = 0; i < NUM_MON; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag[i] <= 1'b0;
            else        flag[i] <= trip[i];
         end
      end
   endgenerate
endmodule

// File: rtl/wr_gate_ctrl_reg.sv
module wr_gate_ctrl_reg
   import wgcr_pkg::*;
#(
   parameter int                      DATA_W         = 8,
   parameter int                      BL_W           = 2,
   parameter int                      PUP_W          = 2,
   parameter int                      COMMIT_CYCLES  = 32,
   parameter logic [BL_W+PUP_W-1:0]   NV_INIT        = '0,
   parameter bit                      WIPER_LOCK_ANY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              arr_wr_req,
   input  logic              wiper_wr_req,
   input  logic              lock_hit,
   input  logic              stop_seen,
   input  logic              mon2_trip,
   input  logic              mon3_trip,
   output logic              wel_q,
   output logic              rwel_q,
   output logic              wr_ack,
   output logic              wr_nak,
   output logic              commit_req,
   output logic              busy,
   output logic [DATA_W-1:0] status_q
);
   localparam int NV_W    = BL_W + PUP_W;
   localparam int NUM_MON = 2;

   generate
      if (DATA_W != NV_W + POS_CFG_LO) begin : g_bad_width
         $error("status byte width must equal configuration width plus four");
      end
      if (COMMIT_CYCLES < 1) begin : g_bad_commit
         $error("COMMIT_CYCLES must be at least one");
      end
   endgenerate

   reg_kind_e          reg_kind;
   logic               reg_take, lock_clr, pend_q;
   logic [NV_W-1:0]    stage_q, nv_q;
   logic [NUM_MON-1:0] flag_q;

   wgcr_permit #(
      .DATA_W(DATA_W), .BL_W(BL_W), .WIPER_LOCK_ANY(WIPER_LOCK_ANY)
   ) u_permit (
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .arr_wr_req(arr_wr_req),
      .wiper_wr_req(wiper_wr_req), .lock_hit(lock_hit), .wel(wel_q),
      .rwel(rwel_q), .busy(busy), .bl(nv_q[BL_W-1:0]),
      .reg_take(reg_take), .reg_kind(reg_kind), .wr_ack(wr_ack),
      .wr_nak(wr_nak), .lock_clr(lock_clr)
   );

   wgcr_latch_seq #(.NV_W(NV_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .reg_take(reg_take), .reg_kind(reg_kind),
      .wel_bit(reg_wdata[POS_WEL]), .cfg_bits(reg_wdata[DATA_W-1 -: NV_W]),
      .lock_clr(lock_clr), .commit(commit_req),
      .wel_q(wel_q), .rwel_q(rwel_q), .pend_q(pend_q), .stage_q(stage_q)
   );

   wgcr_nv_store #(
      .NV_W(NV_W), .COMMIT_CYCLES(COMMIT_CYCLES), .NV_INIT(NV_INIT)
   ) u_nv (
      .clk(clk), .rst_n(rst_n), .stop_seen(stop_seen), .pend(pend_q),
      .stage(stage_q), .commit_req(commit_req), .busy(busy), .nv_q(nv_q)
   );

   wgcr_mon_flags #(.NUM_MON(NUM_MON)) u_flags (
      .clk(clk), .rst_n(rst_n), .trip({mon3_trip, mon2_trip}), .flag(flag_q)
   );

   assign status_q = {nv_q, flag_q[1], rwel_q, wel_q, flag_q[0]};
endmodule

// File: rtl/wgcr_chk.sv
module wgcr_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_wr,
   input logic       arr_wr_req,
   input logic       wiper_wr_req,
   input logic       lock_hit,
   input logic       mon2_trip,
   input logic       wel_q,
   input logic       rwel_q,
   input logic       wr_ack,
   input logic       wr_nak,
   input logic       commit_req,
   input logic       busy,
   input logic [7:0] status_q
);
   // R1
   rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!wel_q && !rwel_q));

   // R4
   unlock_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rwel_q |-> wel_q);

   // R3
   ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_ack && wr_nak));

   // R3
   no_wel_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wel_q && (arr_wr_req || wiper_wr_req)) |-> wr_nak);

   // R8
   busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (reg_wr || arr_wr_req || wiper_wr_req)) |-> (wr_nak && !wr_ack));

   // R8
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(wel_q) && $stable(rwel_q)));

   // R7
   commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_req |=> busy);

   // R9
   lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_wr_req && lock_hit && !reg_wr) |=> !rwel_q);

   // R11
   flag_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (status_q[0] == $past(mon2_trip)));
endmodule

bind wr_gate_ctrl_reg wgcr_chk u_chk (.*);

// File: tb/wr_gate_ctrl_reg_test.sv
`timescale 1ns/1ps
module wr_gate_ctrl_reg_test;
   localparam int CYC = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic       arr_wr_req = 1'b0, wiper_wr_req = 1'b0, lock_hit = 1'b0;
   logic       stop_seen = 1'b0, mon2_trip = 1'b0, mon3_trip = 1'b0;
   logic       wel_q, rwel_q, wr_ack, wr_nak, commit_req, busy;
   logic [7:0] status_q;

   int  n_cmp = 0, n_bad = 0;
   bit  done = 1'b0;

   bit       m_wel, m_rwel, m_pend, m_f2, m_f3;
   bit [3:0] m_nv = 4'h0, m_stage;

   always #2.5 clk = ~clk;

   wr_gate_ctrl_reg #(.COMMIT_CYCLES(CYC)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .arr_wr_req(arr_wr_req), .wiper_wr_req(wiper_wr_req), .lock_hit(lock_hit),
      .stop_seen(stop_seen), .mon2_trip(mon2_trip), .mon3_trip(mon3_trip),
      .wel_q(wel_q), .rwel_q(rwel_q), .wr_ack(wr_ack), .wr_nak(wr_nak),
      .commit_req(commit_req), .busy(busy), .status_q(status_q)
   );

   function automatic logic [7:0] exp_status();
      return {m_nv, m_f3, m_rwel, m_wel, m_f2};
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic pulse_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_wel = 0; m_rwel = 0; m_pend = 0; m_f2 = 0; m_f3 = 0;
      // R1: latches cleared, configuration nibble retained
      check("R1 status after reset", status_q, exp_status());
   endtask

   task automatic reg_write(input logic [7:0] b);
      string tag;
      bit ok;
      if (m_rwel)                     tag = "R6";
      else if (b == 8'h00 || b == 8'h02) tag = "R2";
      else if (b == 8'h06)            tag = "R4";
      else if (m_wel)                 tag = "R5";
      else                            tag = "R3";
      ok = m_rwel || b == 8'h00 || b == 8'h02 || (b == 8'h06 && m_wel);
      @(negedge clk); reg_wr = 1'b1; reg_wdata = b;
      #0.5;
      check({tag, " ack"}, {7'd0, wr_ack}, {7'd0, ok});
      check({tag, " nak"}, {7'd0, wr_nak}, {7'd0, !ok});
      if (ok) begin
         if (m_rwel) begin
            m_wel = b[1]; m_rwel = 0; m_stage = b[7:4]; m_pend = 1;
         end else if (b == 8'h06) m_rwel = 1;
         else m_wel = b[1];
      end
      @(negedge clk); reg_wr = 1'b0;
      // R11: written flag bits must not appear in the status byte
      check({tag, "/R11 status"}, status_q, exp_status());
   endtask

   task automatic stop_cycle();
      bit c;
      int k;
      @(negedge clk); stop_seen = 1'b1;
      #0.5;
      c = m_pend;
      check("R7 commit_req", {7'd0, commit_req}, {7'd0, c});
      @(negedge clk); stop_seen = 1'b0;
      if (c) begin m_nv = m_stage; m_pend = 0; end
      k = 0;
      while (busy && k < 100) begin k++; @(negedge clk); end
      check("R7 busy cycles", 8'(k), c ? 8'(CYC) : 8'd0);
      check("R7 status after stop", status_q, exp_status());
   endtask

   task automatic req_pulse(input bit arr, input bit hit, input bit exp_ok, input string tag);
      @(negedge clk);
      arr_wr_req = arr; wiper_wr_req = !arr; lock_hit = hit;
      #0.5;
      check({tag, " ack"}, {7'd0, wr_ack}, {7'd0, exp_ok});
      check({tag, " nak"}, {7'd0, wr_nak}, {7'd0, !exp_ok});
      if (arr && hit && m_wel) m_rwel = 0;
      @(negedge clk);
      arr_wr_req = 0; wiper_wr_req = 0; lock_hit = 0;
      check({tag, " latches"}, status_q, exp_status());
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_bad++;
         $display("FAIL R7 watchdog act=hung exp=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      pulse_reset();

      // Exhaustive byte sweep from the three latch states: R2 R3 R4 R5 R6 R7
      for (int s = 0; s < 3; s++) begin
         for (int b = 0; b < 256; b++) begin
            pulse_reset();
            if (s >= 1) reg_write(8'h02);
            if (s == 2) reg_write(8'h06);
            reg_write(8'(b));
            stop_cycle();
         end
      end

      // R10 and R9 across every block-lock select
      for (int bl = 0; bl < 4; bl++) begin
         pulse_reset();
         reg_write(8'h02);
         reg_write(8'h06);
         reg_write({2'b00, 2'(bl), 4'b0010});
         stop_cycle();
         req_pulse(1'b0, 1'b0, bl == 0, "R10 wiper");
         reg_write(8'h06);
         req_pulse(1'b1, 1'b0, 1'b1, "R9 array open");
         req_pulse(1'b1, 1'b1, 1'b0, "R9 array locked");
         check("R9 wel kept", {7'd0, wel_q}, 8'd1);
         check("R9 unlock cleared", {7'd0, rwel_q}, 8'd0);
         reg_write(8'h00);
         req_pulse(1'b1, 1'b0, 1'b0, "R3 array no wel");
         req_pulse(1'b0, 1'b0, 1'b0, "R3 wiper no wel");
      end

      // R8: requests during a commit are refused
      pulse_reset();
      reg_write(8'h02);
      reg_write(8'h06);
      reg_write(8'h02);
      @(negedge clk); stop_seen = 1'b1;
      @(negedge clk); stop_seen = 1'b0;
      m_nv = m_stage; m_pend = 0;
      check("R8 busy raised", {7'd0, busy}, 8'd1);
      reg_wr = 1'b1; reg_wdata = 8'h00;
      #0.5;
      check("R8 reg nak", {7'd0, wr_nak}, 8'd1);
      check("R8 reg ack", {7'd0, wr_ack}, 8'd0);
      @(negedge clk); reg_wr = 1'b0; arr_wr_req = 1'b1;
      check("R8 wel held", {7'd0, wel_q}, 8'd1);
      #0.5;
      check("R8 array nak", {7'd0, wr_nak}, 8'd1);
      @(negedge clk); arr_wr_req = 1'b0;
      repeat (CYC) @(negedge clk);
      check("R8 busy ended", {7'd0, busy}, 8'd0);

      // R11: flags follow monitors one cycle later
      for (int m = 0; m < 4; m++) begin
         @(negedge clk); mon2_trip = m[0]; mon3_trip = m[1];
         @(negedge clk);
         m_f2 = m[0]; m_f3 = m[1];
         check("R11 flags", status_q, exp_status());
      end
      @(negedge clk); mon2_trip = 0; mon3_trip = 0;
      @(negedge clk);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule